// File: doc/BRIEF.md
# External IRQ request latch register

This block samples eight external interrupt request pins, decides per pin whether a request is present, and reports the result as a 32-bit status word through a simple register read/write port. Each pin has its own 2-bit sense code that picks one of two edge polarities or one of two level polarities. The pins are first brought into the clock domain through a two-flop synchronizer.

In latched reporting, a detected request sets the pin's flag. The flag stays set until software clears it by reading the bit as 1 and then writing 0 to it. A global reporting flag switches level-sensed pins to live reporting. In live reporting the bit follows the pin, drops when the CPU accepts the request, and ignores writes. The block also drives one request line per pin toward a priority stage. A per-pin mask input gates only those request lines and never touches the status word.

Top module: `irq_latch_reg`

## Requirements
- R1: The flag for pin p is at status bit 31-p. Pin 0 is at bit 31 and pin 7 is at bit 24.
- R2: Status bits 23 down to 0 always read 0, whatever value is written to them.
- R3: While reset is applied, every flag, read data bit and request line goes to 0.
- R4: Sense code 2'b00 detects a falling edge and 2'b01 a rising edge. Code 2'b10 detects a low level and 2'b11 a high level. A pin change is first visible in the flag three clock edges after it is applied. No detection takes place in the first three cycles after reset.
- R5: With latched reporting (edge codes, or level codes while the reporting flag is 0), a set flag stays set after the pin returns to idle.
- R6: Writing 0 to a latched bit clears it only if a read has returned 1 for that bit since the bit was last written. Writing 1 leaves the bit unchanged. Any write to a bit withdraws its clear permission.
- R7: When a detection and a permitted clearing write reach the same bit in the same cycle, the bit stays 1.
- R8: With a level code and the reporting flag at 1, the bit shows "pin active and not yet accepted", and writes to that bit have no effect.
- R9: In live reporting, an accept strobe drives the bit to 0 on the next edge. The bit stays 0 until the pin goes inactive and then active again.
- R10: Request line p is a registered copy of flag p gated by mask bit p. Mask bits never change the status word.
- R11: Read data appears on the edge after a read strobe and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pin_i | input | 8 | Raw external request pins, index = pin number |
| sense_cfg_i | input | 16 | Sense code of pin p at bits 2p+1:2p |
| lvl_report_i | input | 1 | 1 = level-sensed pins report live pin status |
| accept_i | input | 8 | Per-pin CPU acceptance strobe |
| mask_i | input | 8 | Per-pin mask for the request lines |
| rd_en_i | input | 1 | Read strobe for the status word |
| wr_en_i | input | 1 | Write strobe for the status word |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| req_o | output | 8 | Registered request lines toward the priority stage |

## Verification
The hardest case to reach is the collision in R7. The bit must already be set and armed by a read when a fresh detection from the synchronizer lands on the very edge that carries the clearing write. The bench counts the two synchronizer stages and the edge register from the pin change. It then places the zero write so that it arrives exactly three edges after the pin toggle, for every pin and every sense code. The blocked state after an accept in live reporting is also driven for every pin: the bench strobes, then deasserts and reasserts the pin, to show both the hold and its release.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  typedef enum logic [1:0] {
    SENSE_FALL = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_LOW  = 2'b10,
    SENSE_HIGH = 2'b11
  } sense_e;

  function automatic logic mode_is_level(sense_e m);
    return (m == SENSE_LOW) || (m == SENSE_HIGH);
  endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o,
  output logic             ready_o
);
  localparam int WARM  = STAGES + 1;
  localparam int CNT_W = $clog2(WARM + 1);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;
  logic [CNT_W-1:0] warm_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      warm_q <= '0;
    end else begin
      prev_q <= stage_q[STAGES-1];
      if (warm_q != CNT_W'(WARM)) warm_q <= warm_q + 1'b1;
    end
  end

  assign sync_o  = stage_q[STAGES-1];
  assign prev_o  = prev_q;
  assign ready_o = (warm_q == CNT_W'(WARM));
endmodule

// File: rtl/irq_sense_detect.sv
module irq_sense_detect
  import irq_latch_pkg::*;
(
  input  sense_e mode_i,
  input  logic   cur_i,
  input  logic   prev_i,
  input  logic   ready_i,
  output logic   event_o,
  output logic   active_o
);
  logic lvl_active;
  logic hit;

  always_comb begin
    lvl_active = 1'b0;
    hit        = 1'b0;
    unique case (mode_i)
      SENSE_FALL: hit = prev_i & ~cur_i;
      SENSE_RISE: hit = ~prev_i & cur_i;
      SENSE_LOW: begin
        lvl_active = ~cur_i;
        hit        = ~cur_i;
      end
      SENSE_HIGH: begin
        lvl_active = cur_i;
        hit        = cur_i;
      end
      default: hit = 1'b0;
    endcase
  end

  assign event_o  = hit & ready_i;
  assign active_o = lvl_active & ready_i;
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic live_i,
  input  logic event_i,
  input  logic active_i,
  input  logic accept_i,
  input  logic rd_en_i,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic flag_o,
  output logic flag_nxt_o,
  output logic armed_o
);
  logic flag_q, armed_q, blocked_q;
  logic flag_d, armed_d, blocked_d;
  logic clear_ok;

  assign clear_ok = wr_en_i & ~wr_bit_i & armed_q;

  always_comb begin
    if (live_i) flag_d = active_i & ~blocked_q & ~accept_i;
    else        flag_d = event_i | (flag_q & ~clear_ok);

    if (!active_i)            blocked_d = 1'b0;
    else if (live_i && accept_i) blocked_d = 1'b1;
    else                      blocked_d = blocked_q;

    if (wr_en_i)                armed_d = 1'b0;
    else if (rd_en_i && flag_q) armed_d = 1'b1;
    else                        armed_d = armed_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= 1'b0;
      armed_q   <= 1'b0;
      blocked_q <= 1'b0;
    end else begin
      flag_q    <= flag_d;
      armed_q   <= armed_d;
      blocked_q <= blocked_d;
    end
  end

  assign flag_o     = flag_q;
  assign flag_nxt_o = flag_d;
  assign armed_o    = armed_q;
endmodule

// File: rtl/irq_latch_reg.sv
module irq_latch_reg
  import irq_latch_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   irq_pin_i,
  input  logic [2*NUM_PINS-1:0] sense_cfg_i,
  input  logic                  lvl_report_i,
  input  logic [NUM_PINS-1:0]   accept_i,
  input  logic [NUM_PINS-1:0]   mask_i,
  input  logic                  rd_en_i,
  input  logic                  wr_en_i,
  input  logic [WORD_W-1:0]     wr_data_i,
  output logic [WORD_W-1:0]     rd_data_o,
  output logic [NUM_PINS-1:0]   req_o
);
  localparam int TOP_BIT = WORD_W - 1;
  localparam int LOW_W   = WORD_W - NUM_PINS;

  logic [NUM_PINS-1:0] pin_sync, pin_prev;
  logic                det_ready;
  logic [NUM_PINS-1:0] flag_vec, flag_nxt, armed_vec, live_vec, evt_vec, act_vec;
  logic [WORD_W-1:0]   status_word;
  logic [WORD_W-1:0]   rd_q;
  logic [NUM_PINS-1:0] req_q;

  irq_pin_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (irq_pin_i),
    .sync_o (pin_sync),
    .prev_o (pin_prev),
    .ready_o(det_ready)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    sense_e mode;
    assign mode        = sense_e'(sense_cfg_i[2*p +: 2]);
    assign live_vec[p] = mode_is_level(mode) & lvl_report_i;

    irq_sense_detect u_det (
      .mode_i  (mode),
      .cur_i   (pin_sync[p]),
      .prev_i  (pin_prev[p]),
      .ready_i (det_ready),
      .event_o (evt_vec[p]),
      .active_o(act_vec[p])
    );

    irq_flag_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .live_i    (live_vec[p]),
      .event_i   (evt_vec[p]),
      .active_i  (act_vec[p]),
      .accept_i  (accept_i[p]),
      .rd_en_i   (rd_en_i),
      .wr_en_i   (wr_en_i),
      .wr_bit_i  (wr_data_i[TOP_BIT-p]),
      .flag_o    (flag_vec[p]),
      .flag_nxt_o(flag_nxt[p]),
      .armed_o   (armed_vec[p])
    );

    assign status_word[TOP_BIT-p] = flag_vec[p];
  end

  assign status_word[LOW_W-1:0] = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      req_q <= '0;
    end else begin
      if (rd_en_i) rd_q <= status_word;
      req_q <= flag_nxt & ~mask_i;
    end
  end

  assign rd_data_o = rd_q;
  assign req_o     = req_q;
endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk #(
  parameter int NUM_PINS = 8,
  parameter int WORD_W   = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_en_i,
  input logic                wr_en_i,
  input logic [WORD_W-1:0]   wr_data_i,
  input logic [NUM_PINS-1:0] accept_i,
  input logic [NUM_PINS-1:0] mask_i,
  input logic [WORD_W-1:0]   rd_data_o,
  input logic [NUM_PINS-1:0] req_o,
  input logic [NUM_PINS-1:0] flag_vec,
  input logic [NUM_PINS-1:0] armed_vec,
  input logic [NUM_PINS-1:0] live_vec
);
  localparam int LOW_W = WORD_W - NUM_PINS;

  assert_reset_R3: assert property (@(posedge clk)
    rst |=> (rd_data_o == '0) && (req_o == '0) && (flag_vec == '0));

  assert_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (wr_data_i[LOW_W-1:0] != '0)) |=> (rd_data_o[LOW_W-1:0] == '0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    assert_read_copy_R11: assert property (@(posedge clk) disable iff (rst)
      (rd_en_i && !$past(rst)) |=> (rd_data_o[WORD_W-1-i] == $past(flag_vec[i])));

    assert_clear_needs_arm_R6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(flag_vec[i]) && !$past(live_vec[i])) |->
        $past(wr_en_i && !wr_data_i[WORD_W-1-i] && armed_vec[i]));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (!live_vec[i] && flag_vec[i] &&
       !(wr_en_i && !wr_data_i[WORD_W-1-i] && armed_vec[i])) |=>
        (flag_vec[i] || live_vec[i]));

    assert_accept_drop_R9: assert property (@(posedge clk) disable iff (rst)
      (live_vec[i] && accept_i[i]) |=> (!flag_vec[i] || !live_vec[i]));

    assert_mask_gate_R10: assert property (@(posedge clk) disable iff (rst)
      mask_i[i] |=> !req_o[i]);

    assert_req_follows_R10: assert property (@(posedge clk) disable iff (rst)
      req_o[i] |-> flag_vec[i]);
  end
endmodule

bind irq_latch_reg irq_latch_chk #(
  .NUM_PINS(NUM_PINS),
  .WORD_W  (WORD_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en_i  (rd_en_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .accept_i (accept_i),
  .mask_i   (mask_i),
  .rd_data_o(rd_data_o),
  .req_o    (req_o),
  .flag_vec (flag_vec),
  .armed_vec(armed_vec),
  .live_vec (live_vec)
);

// File: tb/irq_latch_reg_bench.sv
module irq_latch_reg_bench;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] irq_pin_i;
  logic [2*NP-1:0] sense_cfg_i;
  logic          lvl_report_i;
  logic [NP-1:0] accept_i;
  logic [NP-1:0] mask_i;
  logic          rd_en_i;
  logic          wr_en_i;
  logic [31:0]   wr_data_i;
  logic [31:0]   rd_data_o;
  logic [NP-1:0] req_o;

  int checks = 0;
  int errors = 0;

  irq_latch_reg u_irq_latch_reg (
    .clk         (clk),
    .rst         (rst),
    .irq_pin_i   (irq_pin_i),
    .sense_cfg_i (sense_cfg_i),
    .lvl_report_i(lvl_report_i),
    .accept_i    (accept_i),
    .mask_i      (mask_i),
    .rd_en_i     (rd_en_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .req_o       (req_o)
  );

  always #10 clk = ~clk;

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_word(output logic [31:0] w);
    rd_en_i = 1'b1;
    tick();
    rd_en_i = 1'b0;
    w = rd_data_o;
  endtask

  task automatic write_word(input logic [31:0] d);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    tick();
    wr_en_i   = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic run_case(input int m, input int l, input int p);
    logic [31:0] w;
    logic [31:0] bitv;
    logic        act_lvl;
    logic        live;
    bitv    = 32'h8000_0000 >> p;           // R1: pin p at bit 31-p
    act_lvl = (m == 1) || (m == 3);
    live    = (m >= 2) && (l == 1);

    rst          = 1'b1;
    irq_pin_i    = {NP{~act_lvl}};
    sense_cfg_i  = {NP{2'(m)}};
    lvl_report_i = 1'(l);
    accept_i     = '0;
    mask_i       = '0;
    rd_en_i      = 1'b0;
    wr_en_i      = 1'b0;
    wr_data_i    = '0;
    tick(2);
    rst = 1'b0;
    check(rd_data_o, 32'h0, "R3 read data after reset");
    check(32'(req_o), 32'h0, "R3 requests after reset");
    tick(5);
    read_word(w);
    check(w, 32'h0, "R4 idle pins give no flag");

    if (!live) begin
      irq_pin_i[p] = act_lvl;
      tick(3);
      check(32'(req_o), 32'(1) << p, "R4 flag visible three edges after toggle");
      irq_pin_i[p] = ~act_lvl;
      tick(4);
      read_word(w);
      check(w, bitv, "R5 R1 flag held after pin idles");
      mask_i[p] = 1'b1;
      tick();
      check(32'(req_o), 32'h0, "R10 mask drops request line");
      read_word(w);
      check(w, bitv, "R10 mask leaves status unchanged");
      mask_i[p] = 1'b0;
      tick();
      check(32'(req_o), 32'(1) << p, "R10 request returns after unmask");

      write_word(32'hFFFF_FFFF);
      read_word(w);
      check(w, bitv, "R2 R6 ones write keeps flag, low bits zero");
      write_word(32'hFFFF_FFFF);
      write_word(32'h0);
      read_word(w);
      check(w, bitv, "R6 zero write without prior read ignored");
      write_word(32'h0);
      read_word(w);
      check(w, 32'h0, "R6 zero write after read clears");

      // collision: set flag, arm it, let a new detection land with the clear
      irq_pin_i[p] = act_lvl;
      tick(4);
      irq_pin_i[p] = ~act_lvl;
      tick(4);
      read_word(w);
      check(w, bitv, "R5 flag set again before collision");
      irq_pin_i[p] = act_lvl;
      tick(2);
      write_word(32'h0);
      read_word(w);
      check(w, bitv, "R7 detection beats clearing write");
      irq_pin_i[p] = ~act_lvl;
      tick(4);
      read_word(w);
      write_word(32'h0);
      read_word(w);
      check(w, 32'h0, "R6 clear after collision");
    end else begin
      irq_pin_i[p] = act_lvl;
      tick(4);
      read_word(w);
      check(w, bitv, "R8 live bit shows active pin");
      check(32'(req_o), 32'(1) << p, "R10 live request line");
      irq_pin_i[p] = ~act_lvl;
      tick(4);
      check(rd_data_o, bitv, "R11 read data holds without read strobe");
      read_word(w);
      check(w, 32'h0, "R8 live bit follows pin release");
      irq_pin_i[p] = act_lvl;
      tick(4);
      read_word(w);
      write_word(32'h0);
      read_word(w);
      check(w, bitv, "R8 write has no effect in live mode");
      accept_i[p] = 1'b1;
      tick();
      accept_i[p] = 1'b0;
      read_word(w);
      check(w, 32'h0, "R9 accept drops live bit");
      tick(3);
      read_word(w);
      check(w, 32'h0, "R9 bit stays low while pin held");
      irq_pin_i[p] = ~act_lvl;
      tick(4);
      irq_pin_i[p] = act_lvl;
      tick(4);
      read_word(w);
      check(w, bitv, "R9 bit returns after pin re-asserts");
    end
    irq_pin_i[p] = ~act_lvl;
  endtask

  initial begin
    rst          = 1'b1;
    irq_pin_i    = '0;
    sense_cfg_i  = '0;
    lvl_report_i = 1'b0;
    accept_i     = '0;
    mask_i       = '0;
    rd_en_i      = 1'b0;
    wr_en_i      = 1'b0;
    wr_data_i    = '0;
    @(negedge clk);
    for (int m = 0; m < 4; m++)
      for (int l = 0; l < 2; l++)
        for (int p = 0; p < NP; p++)
          run_case(m, l, p);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule